// File: doc/BRIEF.md
# Range-Matching Translation Buffer

This block is a small, fully associative buffer that maps virtual addresses to physical ones. Each slot holds a virtual base, a region length and a physical page start. A slot covers every address from its base up to, but not including, base plus length. This lets one slot describe a region of any size rather than a single fixed page. A hit returns the slot's page start combined with the low offset bits of the address. A miss raises a flag and returns zero.

Fills go into an unused slot whenever one exists. Only a full buffer gives up an entry, and the entry it gives up is the one used least recently. Each slot carries a recency rank. A lookup can promote the matched slot, or it can leave the order unchanged, as the caller selects. When regions overlap, the most recently used matching slot answers. A flush input frees every slot in a single cycle.

Top module: `tlb_range`

## Requirements
- R1: A valid slot matches an address `va` when `base <= va` and `va < base + length`; the sum is formed without wrap-around.
- R2: A lookup that hits sets `lk_hit_o` on the cycle after the request edge, with `lk_pa_o` equal to the slot's page start bitwise-ORed with the low `OFF_W` (12) bits of `va`.
- R3: A lookup that matches no slot sets `lk_miss_o`, clears `lk_hit_o` and drives `lk_pa_o` to zero on the cycle after the request.
- R4: An insert writes an unused slot if one exists. Only when all slots are valid does it replace the least recently used slot.
- R5: A newly inserted slot becomes the most recently used.
- R6: A hit with `lk_touch_i` high makes the matched slot the most recently used. With `lk_touch_i` low the recency order does not change.
- R7: When several valid slots cover the address, the most recently used of them answers.
- R8: In a cycle after reset, or after a cycle with no lookup request, both `lk_hit_o` and `lk_miss_o` are low.
- R9: `flush_i` invalidates every slot at the next edge. A lookup or insert presented in the same cycle is discarded: the following cycle shows neither hit nor miss.
- R10: When an insert and a lookup arrive together, the lookup is answered from the contents before the insert, and its promotion is dropped. Only the inserted slot becomes most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all slots |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | VA_W | Lookup virtual address |
| lk_touch_i | input | 1 | Promote the matched slot on a hit |
| lk_hit_o | output | 1 | Registered lookup hit |
| lk_miss_o | output | 1 | Registered lookup miss |
| lk_pa_o | output | PA_W | Registered physical address, zero on a miss |
| ins_req_i | input | 1 | Insert request |
| ins_vbase_i | input | VA_W | Virtual base of the new slot |
| ins_size_i | input | VA_W | Region length of the new slot |
| ins_pstart_i | input | PA_W | Physical page start of the new slot |

## Verification
Every lookup result, whether hit, miss or address, appears exactly one cycle after the clock edge that accepts the request. Inserts, promotions and flushes take effect at that same edge and are visible to the next lookup. The bench drives each request on a falling edge and samples the outputs on the following falling edge, half a cycle after they were registered. Replacement and recency effects are checked indirectly, through later lookups that hit or miss depending on which slot was replaced.

// File: rtl/tlb_range_pkg.sv
package tlb_range_pkg;

    // Action applied to the slot array at the next edge, in priority order.
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_FLUSH   = 2'd1,
        ACT_INSERT  = 2'd2,
        ACT_PROMOTE = 2'd3
    } tlb_act_e;

endpackage

// File: rtl/tlb_range_cmp.sv
module tlb_range_cmp #(
    parameter int VA_W = 32
) (
    input  logic            valid_i,
    input  logic [VA_W-1:0] base_i,
    input  logic [VA_W-1:0] size_i,
    input  logic [VA_W-1:0] va_i,
    output logic            hit_o
);
    logic [VA_W:0] end_w;

    // One extra bit so a region that reaches the top of the space cannot wrap.
    assign end_w = {1'b0, base_i} + {1'b0, size_i};
    assign hit_o = valid_i && (va_i >= base_i) && ({1'b0, va_i} < end_w);
endmodule

// File: rtl/tlb_range_pick.sv
module tlb_range_pick #(
    parameter int N     = 4,
    parameter int AGE_W = 2
) (
    input  logic [N-1:0]            match_i,
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][AGE_W-1:0] age_i,
    output logic                    win_found_o,
    output logic [AGE_W-1:0]        win_idx_o,
    output logic [AGE_W-1:0]        fill_idx_o
);
    logic [AGE_W-1:0] best_age;
    logic             free_found;

    // Youngest matching slot wins (rank 0 is most recent).
    always_comb begin
        win_found_o = 1'b0;
        win_idx_o   = '0;
        best_age    = '1;
        for (int i = 0; i < N; i++) begin
            if (match_i[i] && (!win_found_o || age_i[i] < best_age)) begin
                win_found_o = 1'b1;
                best_age    = age_i[i];
                win_idx_o   = AGE_W'(i);
            end
        end
    end

    // Lowest free slot first, else the slot holding the oldest rank.
    always_comb begin
        free_found = 1'b0;
        fill_idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (!valid_i[i] && !free_found) begin
                free_found = 1'b1;
                fill_idx_o = AGE_W'(i);
            end
        end
        if (!free_found) begin
            for (int i = 0; i < N; i++) begin
                if (age_i[i] == AGE_W'(N - 1)) fill_idx_o = AGE_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_range.sv
module tlb_range
    import tlb_range_pkg::*;
#(
    parameter int N     = 4,
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            flush_i,
    input  logic            lk_req_i,
    input  logic [VA_W-1:0] lk_va_i,
    input  logic            lk_touch_i,
    output logic            lk_hit_o,
    output logic            lk_miss_o,
    output logic [PA_W-1:0] lk_pa_o,
    input  logic            ins_req_i,
    input  logic [VA_W-1:0] ins_vbase_i,
    input  logic [VA_W-1:0] ins_size_i,
    input  logic [PA_W-1:0] ins_pstart_i
);
    localparam int AGE_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]            valid;
        logic [N-1:0][VA_W-1:0]  base;
        logic [N-1:0][VA_W-1:0]  size;
        logic [N-1:0][PA_W-1:0]  pstart;
        logic [N-1:0][AGE_W-1:0] age;
        logic                    hit;
        logic                    miss;
        logic [PA_W-1:0]         pa;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]     match_w;
    logic             win_found_w;
    logic [AGE_W-1:0] win_idx_w;
    logic [AGE_W-1:0] fill_idx_w;
    tlb_act_e         act_w;
    logic [AGE_W-1:0] tgt_w;
    logic [AGE_W-1:0] tgt_age_w;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < N; i++) s.age[i] = AGE_W'(i);
        return s;
    endfunction

    for (genvar g = 0; g < N; g++) begin : g_cmp
        tlb_range_cmp #(.VA_W(VA_W)) u_cmp (
            .valid_i (st_q.valid[g]),
            .base_i  (st_q.base[g]),
            .size_i  (st_q.size[g]),
            .va_i    (lk_va_i),
            .hit_o   (match_w[g])
        );
    end

    tlb_range_pick #(.N(N), .AGE_W(AGE_W)) u_pick (
        .match_i     (match_w),
        .valid_i     (st_q.valid),
        .age_i       (st_q.age),
        .win_found_o (win_found_w),
        .win_idx_o   (win_idx_w),
        .fill_idx_o  (fill_idx_w)
    );

    always_comb begin
        if (flush_i)                                       act_w = ACT_FLUSH;
        else if (ins_req_i)                                act_w = ACT_INSERT;
        else if (lk_req_i && lk_touch_i && win_found_w)    act_w = ACT_PROMOTE;
        else                                               act_w = ACT_NONE;

        tgt_w     = (act_w == ACT_INSERT) ? fill_idx_w : win_idx_w;
        tgt_age_w = st_q.age[tgt_w];

        st_d      = st_q;
        st_d.hit  = 1'b0;
        st_d.miss = 1'b0;
        st_d.pa   = '0;

        // Lookup answered from current contents; dropped during a flush.
        if (lk_req_i && !flush_i) begin
            st_d.hit  = win_found_w;
            st_d.miss = !win_found_w;
            if (win_found_w)
                st_d.pa = st_q.pstart[win_idx_w] | PA_W'(lk_va_i[OFF_W-1:0]);
        end

        if (act_w == ACT_FLUSH) st_d.valid = '0;

        if (act_w == ACT_INSERT) begin
            st_d.valid[tgt_w]  = 1'b1;
            st_d.base[tgt_w]   = ins_vbase_i;
            st_d.size[tgt_w]   = ins_size_i;
            st_d.pstart[tgt_w] = ins_pstart_i;
        end

        // Move target to rank 0; every slot younger than it ages by one.
        if (act_w == ACT_INSERT || act_w == ACT_PROMOTE) begin
            for (int i = 0; i < N; i++) begin
                if (AGE_W'(i) == tgt_w)         st_d.age[i] = '0;
                else if (st_q.age[i] < tgt_age_w) st_d.age[i] = st_q.age[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= reset_state();
        else         st_q <= st_d;
    end

    assign lk_hit_o  = st_q.hit;
    assign lk_miss_o = st_q.miss;
    assign lk_pa_o   = st_q.pa;
endmodule

// File: rtl/tlb_range_chk.sv
module tlb_range_chk #(
    parameter int N     = 4,
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12,
    parameter int AGE_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush_i,
    input logic                    lk_req_i,
    input logic [VA_W-1:0]         lk_va_i,
    input logic                    lk_hit_o,
    input logic                    lk_miss_o,
    input logic [PA_W-1:0]         lk_pa_o,
    input logic [N-1:0]            valid_q,
    input logic [N-1:0][AGE_W-1:0] age_q
);
    logic [(2**AGE_W)-1:0] seen;

    always_comb begin
        seen = '0;
        for (int i = 0; i < N; i++) seen[age_q[i]] = 1'b1;
    end

    // R3: a miss never carries an address and never coincides with a hit
    a_r3_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss_o |-> (lk_pa_o == '0) && !lk_hit_o);

    // R2: offset bits of the request appear in the returned address
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_o |-> ((lk_pa_o[OFF_W-1:0] & $past(lk_va_i[OFF_W-1:0]))
                      == $past(lk_va_i[OFF_W-1:0])));

    // R8: no result without a request in the previous cycle
    a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(lk_req_i) || $past(flush_i)) |-> !lk_hit_o && !lk_miss_o);

    // R9: flush leaves no valid slot
    a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_q == '0));

    // R6: recency ranks stay a permutation
    a_r6_rank_unique: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == N);
endmodule

bind tlb_range tlb_range_chk #(
    .N(N), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .AGE_W(AGE_W)
) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .flush_i   (flush_i),
    .lk_req_i  (lk_req_i),
    .lk_va_i   (lk_va_i),
    .lk_hit_o  (lk_hit_o),
    .lk_miss_o (lk_miss_o),
    .lk_pa_o   (lk_pa_o),
    .valid_q   (st_q.valid),
    .age_q     (st_q.age)
);

// File: tb/test_tlb_range.sv
module test_tlb_range;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_touch = 1'b0;
    logic        lk_hit, lk_miss;
    logic [31:0] lk_pa;
    logic        ins_req = 1'b0;
    logic [31:0] ins_vbase = '0, ins_size = '0, ins_pstart = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tlb_range i_tlb_range (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
        .lk_req_i(lk_req), .lk_va_i(lk_va), .lk_touch_i(lk_touch),
        .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_pa_o(lk_pa),
        .ins_req_i(ins_req), .ins_vbase_i(ins_vbase),
        .ins_size_i(ins_size), .ins_pstart_i(ins_pstart)
    );

    typedef struct packed {
        logic        is_ins;
        logic        touch;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic        eh;
        logic [31:0] ep;
    } vec_t;

    localparam int NV = 22;
    // Insert rows: a=base b=length c=page start. Lookup rows: a=address.
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 32'h1000,  32'h1000, 32'h80000, 1'b0, 32'h0},     // A, R4 free slot
        '{1'b1, 1'b0, 32'h4000,  32'h4000, 32'h90000, 1'b0, 32'h0},     // B
        '{1'b0, 1'b0, 32'h1234,  32'h0, 32'h0, 1'b1, 32'h80234},        // R1 R2
        '{1'b0, 1'b0, 32'h2000,  32'h0, 32'h0, 1'b0, 32'h0},            // R1 upper bound, R3
        '{1'b0, 1'b0, 32'h0FFF,  32'h0, 32'h0, 1'b0, 32'h0},            // R1 lower bound
        '{1'b0, 1'b0, 32'h7FFF,  32'h0, 32'h0, 1'b1, 32'h90FFF},        // R1 last address
        '{1'b0, 1'b0, 32'h4000,  32'h0, 32'h0, 1'b1, 32'h90000},        // R1 base itself
        '{1'b1, 1'b0, 32'h7000,  32'h2000, 32'hA0000, 1'b0, 32'h0},     // C overlaps B
        '{1'b0, 1'b0, 32'h7010,  32'h0, 32'h0, 1'b1, 32'hA0010},        // R5 R7 newest wins
        '{1'b0, 1'b1, 32'h4010,  32'h0, 32'h0, 1'b1, 32'h90010},        // R6 promote B
        '{1'b0, 1'b0, 32'h7010,  32'h0, 32'h0, 1'b1, 32'h90010},        // R6 R7 B now wins
        '{1'b0, 1'b0, 32'h8010,  32'h0, 32'h0, 1'b1, 32'hA0010},        // C only
        '{1'b1, 1'b0, 32'h10000, 32'h1000, 32'hB0000, 1'b0, 32'h0},     // D fills last free
        '{1'b0, 1'b1, 32'h1234,  32'h0, 32'h0, 1'b1, 32'h80234},        // R4 A kept, promote
        '{1'b1, 1'b0, 32'h20000, 32'h1000, 32'hC0000, 1'b0, 32'h0},     // E evicts C (LRU)
        '{1'b0, 1'b0, 32'h8010,  32'h0, 32'h0, 1'b0, 32'h0},            // R4 C gone
        '{1'b0, 1'b0, 32'h20010, 32'h0, 32'h0, 1'b1, 32'hC0010},        // E present
        '{1'b0, 1'b0, 32'h10020, 32'h0, 32'h0, 1'b1, 32'hB0020},        // R6 no touch
        '{1'b1, 1'b0, 32'h30000, 32'h1000, 32'hD0000, 1'b0, 32'h0},     // F evicts B
        '{1'b0, 1'b0, 32'h4010,  32'h0, 32'h0, 1'b0, 32'h0},            // R4 B gone
        '{1'b0, 1'b0, 32'h30020, 32'h0, 32'h0, 1'b1, 32'hD0020},        // F present
        '{1'b0, 1'b0, 32'h1FFF,  32'h0, 32'h0, 1'b1, 32'h80FFF}         // A present
    };

    task automatic chk(input string tag, input logic eh, input logic em,
                       input logic [31:0] ep);
        checks++;
        if (lk_hit !== eh || lk_miss !== em || lk_pa !== ep) begin
            fails++;
            $display("FAIL %s: hit=%0b miss=%0b pa=%h expected hit=%0b miss=%0b pa=%h",
                     tag, lk_hit, lk_miss, lk_pa, eh, em, ep);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic do_ins, input logic [31:0] vb,
                        input logic [31:0] sz, input logic [31:0] ps,
                        input logic do_lk, input logic [31:0] va,
                        input logic touch, input logic do_flush);
        ins_req = do_ins; ins_vbase = vb; ins_size = sz; ins_pstart = ps;
        lk_req = do_lk; lk_va = va; lk_touch = touch; flush = do_flush;
        @(negedge clk);
        ins_req = 1'b0; lk_req = 1'b0; lk_touch = 1'b0; flush = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 in reset", 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 after reset", 1'b0, 1'b0, 32'h0);
        step(1'b0, 0, 0, 0, 1'b1, 32'h1234, 1'b0, 1'b0);
        chk("R3 empty buffer miss", 1'b0, 1'b1, 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].is_ins) begin
                step(1'b1, VEC[k].a, VEC[k].b, VEC[k].c, 1'b0, 0, 1'b0, 1'b0);
                chk($sformatf("row %0d R8 insert without lookup", k), 1'b0, 1'b0, 32'h0);
            end else begin
                step(1'b0, 0, 0, 0, 1'b1, VEC[k].a, VEC[k].touch, 1'b0);
                chk($sformatf("row %0d R1/R2/R3/R4/R6/R7", k),
                    VEC[k].eh, !VEC[k].eh, VEC[k].ep);
            end
        end

        // R10: insert G with a promoting lookup of A; A must stay oldest.
        step(1'b1, 32'h40000, 32'h1000, 32'hE0000, 1'b1, 32'h1234, 1'b1, 1'b0);
        chk("R10 lookup answered with insert", 1'b1, 1'b0, 32'h80234);
        step(1'b0, 0, 0, 0, 1'b1, 32'h10020, 1'b0, 1'b0);
        chk("R4 D replaced by G", 1'b0, 1'b1, 32'h0);
        step(1'b1, 32'h50000, 32'h1000, 32'hF0000, 1'b0, 0, 1'b0, 1'b0);
        step(1'b0, 0, 0, 0, 1'b1, 32'h1234, 1'b0, 1'b0);
        chk("R10 promotion dropped, A evicted", 1'b0, 1'b1, 32'h0);
        step(1'b0, 0, 0, 0, 1'b1, 32'h50010, 1'b0, 1'b0);
        chk("R5 H present", 1'b1, 1'b0, 32'hF0010);

        // R10: lookup of the region being inserted sees the old contents.
        step(1'b1, 32'h60000, 32'h1000, 32'h70000, 1'b1, 32'h60010, 1'b0, 1'b0);
        chk("R10 lookup before insert lands", 1'b0, 1'b1, 32'h0);
        step(1'b0, 0, 0, 0, 1'b1, 32'h60010, 1'b0, 1'b0);
        chk("R10 inserted slot visible next", 1'b1, 1'b0, 32'h70010);

        // R9: flush discards same-cycle lookup and insert.
        step(1'b1, 32'h90000, 32'h1000, 32'h11000, 1'b1, 32'h50010, 1'b1, 1'b1);
        chk("R9 lookup in flush cycle", 1'b0, 1'b0, 32'h0);
        step(1'b0, 0, 0, 0, 1'b1, 32'h50010, 1'b0, 1'b0);
        chk("R9 flushed slot misses", 1'b0, 1'b1, 32'h0);
        step(1'b0, 0, 0, 0, 1'b1, 32'h90010, 1'b0, 1'b0);
        chk("R9 insert in flush cycle dropped", 1'b0, 1'b1, 32'h0);

        // R4: after flush, four inserts all land in free slots.
        for (int k = 0; k < 4; k++)
            step(1'b1, 32'h100000 * (k + 1), 32'h1000, 32'h200000 * (k + 1),
                 1'b0, 0, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 0, 0, 0, 1'b1, 32'h100000 * (k + 1) + 32'h0ABC, 1'b0, 1'b0);
            chk($sformatf("R4 refill slot %0d kept", k), 1'b1, 1'b0,
                32'h200000 * (k + 1) + 32'h0ABC);
        end
        // R1: region ending at the top of the address space does not wrap.
        step(1'b1, 32'hFFFF_F000, 32'h1000, 32'h0030_0000, 1'b0, 0, 1'b0, 1'b0);
        step(1'b0, 0, 0, 0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
        chk("R1 top-of-space region", 1'b1, 1'b0, 32'h0030_0FFF);
        @(negedge clk);
        chk("R8 idle after lookup", 1'b0, 1'b0, 32'h0);

        finish_run();
    end
endmodule